// File: doc/BRIEF.md
# Masked Interrupt Distributor for Four Processors

The distributor gathers 64 device interrupt lines into a raw request vector and fans them out to four processor targets. Each target owns a 64-bit enable mask. Its effective pending vector is always the mask ANDed with the raw requests, and it is driven continuously on a per-target level output. Every change that a target must be told about leaves the block as a discrete event. An event names the target, the 6-bit line number and whether it is a post or a clear. Because each event carries its own line number, two sources that change in the same operation never merge into one notification.

Three input streams drive the block: device post/clear requests that carry a line index, commands to an 8-bit cascaded legacy controller that feeds line 55, and a single-cycle register port. The register port rewrites masks and reads masks, pending vectors and the raw vector. The block accepts one operation per cycle and expands it into a batch of events. Until the batch has drained through the valid/ready event port, every input stream sees `ready` low. A consumer that holds `evt_ready` low therefore stalls the whole block. The event on the port stays frozen until `evt_ready` is high.

Top module: `irq_distributor`

## Requirements
- R1: After reset all masks, the raw vector and the legacy request and mask are zero: `irq_level` is 0, `evt_valid` is 0, `reg_err` is 0, all three input `ready` signals are 1, and reads of the mask and raw registers return 0.
- R2: Bits `[k*64 +: 64]` of `irq_level` always equal mask k ANDed with the raw vector.
- R3: A device post (`dev_clear`=0) of line n sets raw bit n. Every target k whose mask has bit n set receives a post event (`evt_clear`=0, `evt_tgt`=k, `evt_line`=n). This happens even if raw bit n was already set.
- R4: A device clear of line n while raw bit n is 0 is spurious. It emits no event and changes no state.
- R5: A device clear of line n while raw bit n is 1 resets raw bit n. Every target whose pending bit n was set receives a clear event (`evt_clear`=1) for n.
- R6: A write to mask k compares the old and new values. A line that becomes enabled while its raw bit is set gives a post to k. A line that becomes disabled while its raw bit is set gives a clear to k. Unchanged bits give nothing.
- R7: The events of one operation leave in ascending order of the flat index target*64+line. While `evt_valid` is 1 and `evt_ready` is 0, the event fields hold still.
- R8: While any event is outstanding, `reg_ready`, `leg_ready` and `dev_ready` are 0. When idle, the register port wins over the legacy port, and the legacy port wins over the device port. Each of these `ready` signals is 1 only if no higher-ranked `valid` is present.
- R9: The register selector is `reg_addr >> 6`; the low 6 address bits are ignored. Selectors 0–3 are masks 0–3 (read/write), 4–7 are pending vectors 0–3 (read only), and 8 is the raw vector (read only). Read data appears on `reg_rdata` in the cycle after acceptance and holds until the next read.
- R10: A write to selector 4–8, a write to an unmapped selector, or a read of an unmapped selector sets the sticky `reg_err`. Such an access changes no state and emits no event. An unmapped read returns 0.
- R11: Legacy commands have these encodings: `leg_cmd` 0 ORs `leg_data` into the legacy requests, 1 clears the bits set in `leg_data`, 2 loads the legacy mask, and 3 does nothing. When the legacy requests ANDed with the legacy mask go from zero to nonzero, the block performs a post of line 55. When they go from nonzero to zero, it performs a clear of line 55. Any other command causes no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access request |
| reg_ready | output | 1 | Register access accepted when high with reg_valid |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 10 | Byte offset; selector is bits 9:6 |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, registered |
| reg_err | output | 1 | Sticky access error |
| dev_valid | input | 1 | Device request valid |
| dev_ready | output | 1 | Device request accepted |
| dev_clear | input | 1 | 0 = post, 1 = clear |
| dev_line | input | 6 | Interrupt line index |
| leg_valid | input | 1 | Legacy command valid |
| leg_ready | output | 1 | Legacy command accepted |
| leg_cmd | input | 2 | Legacy command code |
| leg_data | input | 8 | Legacy command operand |
| irq_level | output | 256 | Pending vectors of all targets, target k in bits k*64+63:k*64 |
| evt_valid | output | 1 | Event available |
| evt_ready | input | 1 | Consumer takes event |
| evt_clear | output | 1 | 0 = post, 1 = clear |
| evt_tgt | output | 2 | Target index |
| evt_line | output | 6 | Line number |

## Verification
Device posts are swept over all 64 lines against four masks of different density. This separates routing by mask from routing to all targets, and a single-target batch from a four-target batch. Clears are swept over the even lines and then repeated on a line that is already clear, so a real clear can be told apart from a spurious one. Mask rewrites are tried with three kinds of value: an inverted pattern that gives interleaved posts and clears to check ordering, an identical value that must stay silent, and a one-bit change. Simultaneous valids on all ports probe the arbitration, and a legacy command sequence checks that only edges of the masked legacy request reach line 55.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  typedef enum logic [1:0] {
    LEG_SET  = 2'd0,
    LEG_CLR  = 2'd1,
    LEG_MASK = 2'd2,
    LEG_NOP  = 2'd3
  } leg_cmd_e;
endpackage

// File: rtl/irqd_cascade.sv
module irqd_cascade
  import irqd_pkg::*;
#(
  parameter int LEG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [1:0]       cmd,
  input  logic [LEG_W-1:0] data,
  output logic             raise,
  output logic             drop
);
  logic [LEG_W-1:0] req_q, msk_q, req_d, msk_d;
  leg_cmd_e         c;
  logic             act_now, act_nxt;

  assign c = leg_cmd_e'(cmd);

  always_comb begin
    req_d = req_q;
    msk_d = msk_q;
    unique case (c)
      LEG_SET:  req_d = req_q | data;
      LEG_CLR:  req_d = req_q & ~data;
      LEG_MASK: msk_d = data;
      default:  ;
    endcase
  end

  assign act_now = |(req_q & msk_q);
  assign act_nxt = |(req_d & msk_d);
  assign raise   = fire & ~act_now & act_nxt;
  assign drop    = fire & act_now & ~act_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      msk_q <= '0;
    end else if (fire) begin
      req_q <= req_d;
      msk_q <= msk_d;
    end
  end
endmodule

// File: rtl/irqd_lane.sv
module irqd_lane #(
  parameter int LINE_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [(1<<LINE_W)-1:0] raw_q,
  input  logic                   op_post,
  input  logic                   op_clr,
  input  logic [LINE_W-1:0]      op_line,
  input  logic                   mwr,
  input  logic [(1<<LINE_W)-1:0] mdata,
  output logic [(1<<LINE_W)-1:0] mask_q,
  output logic [(1<<LINE_W)-1:0] pend,
  output logic [(1<<LINE_W)-1:0] add_post,
  output logic [(1<<LINE_W)-1:0] add_clr
);
  localparam int N = 1 << LINE_W;
  logic [N-1:0] onehot, chg;

  assign onehot = N'(1) << op_line;
  assign pend   = mask_q & raw_q;
  assign chg    = mask_q ^ mdata;

  always_comb begin
    add_post = '0;
    add_clr  = '0;
    if (mwr) begin
      add_post = chg & mdata & raw_q;
      add_clr  = chg & ~mdata & raw_q;
    end else if (op_post) begin
      add_post = onehot & mask_q;
    end else if (op_clr) begin
      add_clr  = onehot & pend;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   mask_q <= '0;
    else if (mwr) mask_q <= mdata;
  end
endmodule

// File: rtl/irqd_evq.sv
module irqd_evq #(
  parameter int LINE_W = 6,
  parameter int TGT_W  = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            load,
  input  logic [(1<<(LINE_W+TGT_W))-1:0]  ld_post,
  input  logic [(1<<(LINE_W+TGT_W))-1:0]  ld_clr,
  input  logic                            take,
  output logic                            valid,
  output logic                            is_clr,
  output logic [TGT_W-1:0]                tgt,
  output logic [LINE_W-1:0]               line
);
  localparam int IW  = LINE_W + TGT_W;
  localparam int TOT = 1 << IW;

  logic [TOT-1:0] post_q, clr_q, any;
  logic [IW-1:0]  idx;
  logic           found;

  assign any = post_q | clr_q;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = TOT - 1; i >= 0; i--) begin
      if (any[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  assign valid  = found;
  assign is_clr = clr_q[idx];
  assign tgt    = idx[IW-1:LINE_W];
  assign line   = idx[LINE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      post_q <= '0;
      clr_q  <= '0;
    end else if (load) begin
      post_q <= ld_post;
      clr_q  <= ld_clr;
    end else if (found && take) begin
      post_q[idx] <= 1'b0;
      clr_q[idx]  <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor #(
  parameter int LINE_W    = 6,
  parameter int TGT_W     = 2,
  parameter int ADDR_W    = 10,
  parameter int SEL_SHIFT = 6,
  parameter int LEG_W     = 8,
  parameter int LEG_LINE  = 55
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     reg_valid,
  output logic                                     reg_ready,
  input  logic                                     reg_write,
  input  logic [ADDR_W-1:0]                        reg_addr,
  input  logic [(1<<LINE_W)-1:0]                   reg_wdata,
  output logic [(1<<LINE_W)-1:0]                   reg_rdata,
  output logic                                     reg_err,
  input  logic                                     dev_valid,
  output logic                                     dev_ready,
  input  logic                                     dev_clear,
  input  logic [LINE_W-1:0]                        dev_line,
  input  logic                                     leg_valid,
  output logic                                     leg_ready,
  input  logic [1:0]                               leg_cmd,
  input  logic [LEG_W-1:0]                         leg_data,
  output logic [(1<<TGT_W)*(1<<LINE_W)-1:0]        irq_level,
  output logic                                     evt_valid,
  input  logic                                     evt_ready,
  output logic                                     evt_clear,
  output logic [TGT_W-1:0]                         evt_tgt,
  output logic [LINE_W-1:0]                        evt_line
);
  localparam int N       = 1 << LINE_W;
  localparam int NUM_TGT = 1 << TGT_W;
  localparam int SEL_W   = ADDR_W - SEL_SHIFT;
  localparam int TOT     = NUM_TGT * N;

  logic [SEL_W-1:0]  sel;
  logic              reg_fire, leg_fire, dev_fire, busy;
  logic              is_mask, is_pend, is_raw, mapped;
  logic              wr_bad, rd_bad;
  logic [N-1:0]      raw_q, rd_mux;
  logic [N-1:0]      mask_arr [NUM_TGT];
  logic [N-1:0]      pend_arr [NUM_TGT];
  logic [TOT-1:0]    add_post_all, add_clr_all;
  logic              cas_raise, cas_drop;
  logic              op_post, op_clr_req, op_clr;
  logic [LINE_W-1:0] op_line;
  logic              unused_addr_lo;

  assign unused_addr_lo = ^reg_addr[SEL_SHIFT-1:0];

  // one operation per cycle; register > legacy > device
  assign reg_ready = ~busy;
  assign leg_ready = ~busy & ~reg_valid;
  assign dev_ready = ~busy & ~reg_valid & ~leg_valid;
  assign reg_fire  = reg_valid & reg_ready;
  assign leg_fire  = leg_valid & leg_ready;
  assign dev_fire  = dev_valid & dev_ready;

  assign sel     = reg_addr[ADDR_W-1:SEL_SHIFT];
  assign is_mask = sel < SEL_W'(NUM_TGT);
  assign is_pend = (sel >= SEL_W'(NUM_TGT)) && (sel < SEL_W'(2*NUM_TGT));
  assign is_raw  = sel == SEL_W'(2*NUM_TGT);
  assign mapped  = is_mask | is_pend | is_raw;
  assign wr_bad  = reg_fire & reg_write & ~is_mask;
  assign rd_bad  = reg_fire & ~reg_write & ~mapped;

  irqd_cascade #(.LEG_W(LEG_W)) u_cas (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (leg_fire),
    .cmd   (leg_cmd),
    .data  (leg_data),
    .raise (cas_raise),
    .drop  (cas_drop)
  );

  // line operation from the legacy cascade or a device
  always_comb begin
    if (leg_fire) begin
      op_line    = LINE_W'(LEG_LINE);
      op_post    = cas_raise;
      op_clr_req = cas_drop;
    end else begin
      op_line    = dev_line;
      op_post    = dev_fire & ~dev_clear;
      op_clr_req = dev_fire & dev_clear;
    end
  end
  assign op_clr = op_clr_req & raw_q[op_line];

  always_ff @(posedge clk) begin
    if (!rst_n)       raw_q <= '0;
    else if (op_post) raw_q[op_line] <= 1'b1;
    else if (op_clr)  raw_q[op_line] <= 1'b0;
  end

  for (genvar k = 0; k < NUM_TGT; k++) begin : g_lane
    logic mwr_k;
    assign mwr_k = reg_fire & reg_write & (sel == SEL_W'(k));
    irqd_lane #(.LINE_W(LINE_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_q    (raw_q),
      .op_post  (op_post),
      .op_clr   (op_clr),
      .op_line  (op_line),
      .mwr      (mwr_k),
      .mdata    (reg_wdata),
      .mask_q   (mask_arr[k]),
      .pend     (pend_arr[k]),
      .add_post (add_post_all[k*N +: N]),
      .add_clr  (add_clr_all[k*N +: N])
    );
    assign irq_level[k*N +: N] = pend_arr[k];
  end

  irqd_evq #(.LINE_W(LINE_W), .TGT_W(TGT_W)) u_evq (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (reg_fire | leg_fire | dev_fire),
    .ld_post (add_post_all),
    .ld_clr  (add_clr_all),
    .take    (evt_ready),
    .valid   (evt_valid),
    .is_clr  (evt_clear),
    .tgt     (evt_tgt),
    .line    (evt_line)
  );
  assign busy = evt_valid;

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_TGT; k++) begin
      if (sel == SEL_W'(k))           rd_mux = mask_arr[k];
      if (sel == SEL_W'(NUM_TGT + k)) rd_mux = pend_arr[k];
    end
    if (is_raw) rd_mux = raw_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      reg_err   <= 1'b0;
    end else begin
      if (reg_fire && !reg_write) reg_rdata <= rd_mux;
      if (wr_bad || rd_bad)       reg_err   <= 1'b1;
    end
  end
endmodule

// File: rtl/irqd_chk.sv
module irqd_chk #(
  parameter int LINE_W = 6,
  parameter int TGT_W  = 2,
  parameter int SEL_W  = 4
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 reg_valid,
  input logic                                 reg_ready,
  input logic                                 reg_write,
  input logic [SEL_W-1:0]                     reg_sel,
  input logic                                 reg_err,
  input logic                                 leg_ready,
  input logic                                 dev_valid,
  input logic                                 dev_ready,
  input logic                                 dev_clear,
  input logic [LINE_W-1:0]                    dev_line,
  input logic [(1<<LINE_W)-1:0]               raw,
  input logic [(1<<TGT_W)*(1<<LINE_W)-1:0]    irq_level,
  input logic                                 evt_valid,
  input logic                                 evt_ready,
  input logic                                 evt_clear,
  input logic [TGT_W-1:0]                     evt_tgt,
  input logic [LINE_W-1:0]                    evt_line
);
  localparam int NUM_TGT = 1 << TGT_W;
  logic [TGT_W+LINE_W-1:0] eidx;
  assign eidx = {evt_tgt, evt_line};

  AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |=> evt_valid && $stable(evt_tgt) && $stable(evt_line) && $stable(evt_clear)); // R7

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> !reg_ready && !leg_ready && !dev_ready); // R8

  AST_EVT_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> irq_level[eidx] == !evt_clear); // R6

  AST_SPURIOUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid && dev_ready && dev_clear && !raw[dev_line] |=> !evt_valid && $stable(irq_level)); // R4

  AST_RO_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && reg_ready && reg_write && (reg_sel >= SEL_W'(NUM_TGT)) |=> !evt_valid && $stable(irq_level) && reg_err); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_err |=> reg_err); // R10
endmodule

bind irq_distributor irqd_chk #(
  .LINE_W (LINE_W),
  .TGT_W  (TGT_W),
  .SEL_W  (ADDR_W - SEL_SHIFT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_valid (reg_valid),
  .reg_ready (reg_ready),
  .reg_write (reg_write),
  .reg_sel   (sel),
  .reg_err   (reg_err),
  .leg_ready (leg_ready),
  .dev_valid (dev_valid),
  .dev_ready (dev_ready),
  .dev_clear (dev_clear),
  .dev_line  (dev_line),
  .raw       (raw_q),
  .irq_level (irq_level),
  .evt_valid (evt_valid),
  .evt_ready (evt_ready),
  .evt_clear (evt_clear),
  .evt_tgt   (evt_tgt),
  .evt_line  (evt_line)
);

// File: tb/sim_irq_distributor.sv
`timescale 1ns/100ps
module sim_irq_distributor;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_valid = 1'b0, reg_write = 1'b0;
  logic [9:0]   reg_addr = '0;
  logic [63:0]  reg_wdata = '0;
  logic         reg_ready, reg_err;
  logic [63:0]  reg_rdata;
  logic         dev_valid = 1'b0, dev_clear = 1'b0, dev_ready;
  logic [5:0]   dev_line = '0;
  logic         leg_valid = 1'b0, leg_ready;
  logic [1:0]   leg_cmd = '0;
  logic [7:0]   leg_data = '0;
  logic [255:0] irq_level;
  logic         evt_valid, evt_clear;
  logic         evt_ready = 1'b1;
  logic [1:0]   evt_tgt;
  logic [5:0]   evt_line;

  always #2 clk = ~clk;

  irq_distributor u0 (.*);

  int total = 0, bad = 0;
  bit done = 0;
  logic [63:0] m_raw;
  logic [63:0] m_mask [4];
  logic [7:0]  m_lreq, m_lmsk;
  int e_n = 0;
  int e_tgt [256];
  int e_line [256];
  bit e_clr [256];

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic push(int t, int n, bit c);
    e_tgt[e_n] = t; e_line[e_n] = n; e_clr[e_n] = c; e_n++;
  endtask

  task automatic model_post(int n);
    for (int t = 0; t < 4; t++) if (m_mask[t][n]) push(t, n, 1'b0);
    m_raw[n] = 1'b1;
  endtask

  task automatic model_clear(int n);
    if (m_raw[n]) begin
      for (int t = 0; t < 4; t++) if (m_mask[t][n]) push(t, n, 1'b1);
      m_raw[n] = 1'b0;
    end
  endtask

  task automatic drain(string req, bit stall);
    for (int i = 0; i < e_n; i++) begin
      if (i > 0) @(negedge clk);
      chk(req, "evt_valid", 64'(evt_valid), 64'd1);
      chk(req, "evt_tgt",   64'(evt_tgt),   64'(e_tgt[i]));
      chk(req, "evt_line",  64'(evt_line),  64'(e_line[i]));
      chk(req, "evt_clear", 64'(evt_clear), 64'(e_clr[i]));
      if (stall && i == 0) begin
        evt_ready = 1'b0;
        for (int s = 0; s < 3; s++) begin
          @(negedge clk);
          chk("R7", "held event", {evt_valid, evt_clear, evt_tgt, evt_line},
              {1'b1, e_clr[0], 2'(e_tgt[0]), 6'(e_line[0])});
          chk("R8", "ready while busy", {reg_ready, leg_ready, dev_ready}, 3'b000);
        end
        evt_ready = 1'b1;
      end
    end
    if (e_n > 0) @(negedge clk);
    chk(req, "no extra event", 64'(evt_valid), 64'd0);
    e_n = 0;
    for (int t = 0; t < 4; t++)
      chk("R2", $sformatf("irq_level tgt%0d", t), irq_level[t*64 +: 64], m_mask[t] & m_raw);
  endtask

  task automatic dev_op(bit c, int n, bit stall);
    string req;
    req = c ? (m_raw[n] ? "R5" : "R4") : "R3";
    if (c) model_clear(n); else model_post(n);
    @(negedge clk);
    dev_valid = 1'b1; dev_clear = c; dev_line = 6'(n);
    @(negedge clk);
    dev_valid = 1'b0;
    drain(req, stall);
  endtask

  task automatic reg_wr(int sel, logic [63:0] d, bit stall);
    if (sel < 4) begin
      for (int n = 0; n < 64; n++)
        if ((m_mask[sel][n] != d[n]) && m_raw[n]) push(sel, n, ~d[n]);
      m_mask[sel] = d;
    end
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 10'((sel << 6) | ((sel * 13) & 63)); reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
    drain(sel < 4 ? "R6" : "R10", stall);
  endtask

  task automatic reg_rd(int sel, logic [63:0] exp, string req);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = 10'((sel << 6) | 37);
    @(negedge clk);
    reg_valid = 1'b0;
    chk(req, $sformatf("read sel %0d", sel), reg_rdata, exp);
    chk(req, "read makes no event", 64'(evt_valid), 64'd0);
  endtask

  task automatic leg_op(int cmd, logic [7:0] d);
    bit a0, a1;
    a0 = |(m_lreq & m_lmsk);
    case (cmd)
      0: m_lreq = m_lreq | d;
      1: m_lreq = m_lreq & ~d;
      2: m_lmsk = d;
      default: ;
    endcase
    a1 = |(m_lreq & m_lmsk);
    if (!a0 && a1) model_post(55);
    if (a0 && !a1) model_clear(55);
    @(negedge clk);
    leg_valid = 1'b1; leg_cmd = 2'(cmd); leg_data = d;
    @(negedge clk);
    leg_valid = 1'b0;
    drain("R11", 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [63:0] pat;
    m_raw = '0; m_lreq = '0; m_lmsk = '0;
    for (int t = 0; t < 4; t++) m_mask[t] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk("R1", "irq_level", irq_level[63:0] | irq_level[127:64] | irq_level[191:128] | irq_level[255:192], 64'd0);
    chk("R1", "evt_valid", 64'(evt_valid), 64'd0);
    chk("R1", "reg_err", 64'(reg_err), 64'd0);
    chk("R1", "readies", {reg_ready, leg_ready, dev_ready}, 3'b111);
    reg_rd(8, 64'd0, "R1");
    reg_rd(0, 64'd0, "R1");

    // masks of differing density; raw is empty so no events
    pat = 64'hA5C3_0F96_3C5A_E187;
    reg_wr(0, '1, 1'b0);
    reg_wr(1, 64'h5555_5555_5555_5555, 1'b0);
    reg_wr(2, pat, 1'b0);
    reg_wr(3, pat >> 7, 1'b0);

    // R3: post every line
    for (int n = 0; n < 64; n++) dev_op(1'b0, n, n == 6);
    dev_op(1'b0, 9, 1'b0);

    // R9: read back all mapped registers
    for (int k = 0; k < 4; k++) reg_rd(k, m_mask[k], "R9");
    for (int k = 0; k < 4; k++) reg_rd(4 + k, m_mask[k] & m_raw, "R9");
    reg_rd(8, m_raw, "R9");

    // R6: inverted, identical and single-bit mask rewrites
    reg_wr(1, ~m_mask[1], 1'b1);
    reg_wr(2, m_mask[2], 1'b0);
    reg_wr(0, m_mask[0] & ~(64'd1 << 55), 1'b0);
    reg_wr(3, m_mask[3] | 64'd1, 1'b0);

    // R5 and R4: clears, then spurious clears
    for (int n = 0; n < 64; n += 2) dev_op(1'b1, n, n == 4);
    dev_op(1'b1, 0, 1'b0);
    dev_op(1'b1, 62, 1'b0);

    // R8: arbitration, checked combinationally and withdrawn before the edge
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = 10'h200; leg_valid = 1'b1; dev_valid = 1'b1;
    #0.4 chk("R8", "reg wins", {reg_ready, leg_ready, dev_ready}, 3'b100);
    reg_valid = 1'b0;
    #0.4 chk("R8", "legacy beats device", {leg_ready, dev_ready}, 2'b10);
    leg_valid = 1'b0;
    #0.4 chk("R8", "device alone", 64'(dev_ready), 64'd1);
    dev_valid = 1'b0;
    @(negedge clk);
    chk("R8", "nothing fired", 64'(evt_valid), 64'd0);

    // R11: legacy cascade onto line 55
    leg_op(2, 8'h04);
    leg_op(0, 8'h01);
    leg_op(0, 8'h04);
    leg_op(0, 8'h10);
    leg_op(3, 8'hFF);
    leg_op(1, 8'h04);
    leg_op(1, 8'h01);
    leg_op(0, 8'h04);
    leg_op(2, 8'h00);

    // R10: illegal accesses
    chk("R10", "err clear before bad access", 64'(reg_err), 64'd0);
    reg_wr(5, '1, 1'b0);
    chk("R10", "err after pending write", 64'(reg_err), 64'd1);
    reg_wr(8, '0, 1'b0);
    reg_wr(12, '1, 1'b0);
    reg_rd(8, m_raw, "R10");
    reg_rd(12, 64'd0, "R10");
    chk("R10", "err sticky", 64'(reg_err), 64'd1);
    for (int k = 0; k < 4; k++) reg_rd(k, m_mask[k], "R10");

    summary();
  end
endmodule